// File: doc/BRIEF.md
# Display Controller Register Block

A 32-bit memory-mapped register block for a display controller. It stores the controller's control, configuration, colour-key, timing, panel-size and graphics-layer settings. It applies a fixed field mask to every write. It drives one level-sensitive interrupt from a write-one-to-clear status register, which is gated by a 16-bit enable mask. The pixel pipeline reads the stored values. Software reaches the block through a single-cycle request port. A frame-completion pulse from the pipeline sets status bit 0.

Two panel enables are taken directly from the control register. Panel and layer sizes are stored minus one: the all-zero reset value stands for a 1x1 area. Setting bit 1 in a write to the system-configuration register returns every register to its reset value in one cycle. An address window reserved for the video planes reads as zero and ignores writes. Any other unmapped or unaligned read returns zero and raises an error flag.

Top module: `dispc_regs`

## Requirements
- R1: After reset, every stored register reads 0 with three exceptions: capability reads 0x161, row increment reads 1 and pixel increment reads 1.
- R2: Each write keeps only the register's field mask. The masks are: sysconfig 0x301B, config 0x3FFF, capability 0x3FF, the two background and two key colours 0xFFFFFF, line number 0x7FF, horizontal and vertical timing 0x0FF0FF3F, polarity 0x0003FFFF, divisor 0x00FF00FF, attributes 0x7FF, FIFO threshold 0x01FF01FF. The two base addresses, row increment, pixel increment, window skip and table base keep all 32 bits. The byte offsets are: rev 0x00, sysstat 0x04, syscfg 0x08, irq status 0x0C, irq enable 0x10, control 0x14, config 0x18, capability 0x1C, bg0 0x20, bg1 0x24, key0 0x28, key1 0x2C, line status 0x30, line number 0x34, htiming 0x38, vtiming 0x3C, polarity 0x40, divisor 0x44, digital size 0x48, LCD size 0x4C, base0 0x50, base1 0x54, position 0x58, layer size 0x5C, attributes 0x60, threshold 0x64, FIFO status 0x68, row inc 0x6C, pixel inc 0x70, window skip 0x74, table base 0x78.
- R3: Four registers are constant and ignore writes: revision reads 0x20, system status reads 1, line status reads 0x7FF, FIFO status reads 256.
- R4: The control register keeps value & 0x07FF9FFF. Output lcd_en equals its bit 0 and dig_en equals its bit 1.
- R5: The two panel-size registers, the layer-size register and the position register keep bits 10:0 and 26:16 (mask 0x07FF07FF). For the size registers, these fields hold width minus one and height minus one. Reads return the same encoding.
- R6: Writing irq status clears each bit set in the written value. Irq enable keeps the low 16 bits.
- R7: A frame_done pulse sets status bit 0 at the same edge. If a clearing write or a soft reset lands on that edge, the set wins.
- R8: irq is high exactly when (status AND enable) is nonzero, from the edge that changes either register.
- R9: A sysconfig write with bit 1 set restores every register to its R1 value. The idle field then takes value & 0x301B.
- R10: Aligned addresses 0x80 to 0xFC read 0, ignore writes and do not raise bad_addr.
- R11: Reads of any other unmapped or unaligned address return 0 with bad_addr high for that response. Writes there change nothing.
- R12: An accepted read (req_valid high, req_write low) gives rd_valid and rd_data one cycle later. rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| frame_done | input | 1 | Frame-completion pulse; sets status bit 0 |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| bad_addr | output | 1 | Read hit an unmapped or unaligned address |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | LCD panel enable |
| dig_en | output | 1 | Digital panel enable |

## Verification
The hardest case to reach from the ports is a clearing write to status bit 0 that lands on the same edge as a frame_done pulse. A soft reset on that edge is just as hard to reach. The bench drives both collisions directly. It also lets the random traffic raise frame_done in roughly one cycle in eight while irq-status writes and sysconfig writes are frequent, so such collisions also occur with varied enable masks. The expected value of irq is checked after every cycle against the bench's own model.

// File: rtl/dispc_regs.sv
module dispc_regs #(
  parameter int ADDR_W = 10,
  parameter int IRQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              frame_done,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              bad_addr,
  output logic              irq,
  output logic              lcd_en,
  output logic              dig_en
);
  localparam logic [ADDR_W-1:0] A_REV = 'h00, A_SSTAT = 'h04, A_SCFG = 'h08, A_ISTAT = 'h0C,
    A_IEN = 'h10, A_CTRL = 'h14, A_CFG = 'h18, A_CAP = 'h1C, A_BG0 = 'h20, A_BG1 = 'h24,
    A_KEY0 = 'h28, A_KEY1 = 'h2C, A_LSTAT = 'h30, A_LINE = 'h34, A_HTIM = 'h38, A_VTIM = 'h3C,
    A_POL = 'h40, A_DIV = 'h44, A_DSIZE = 'h48, A_LSIZE = 'h4C, A_BASE0 = 'h50, A_BASE1 = 'h54,
    A_POS = 'h58, A_GSIZE = 'h5C, A_ATTR = 'h60, A_THR = 'h64, A_FSTAT = 'h68, A_ROWI = 'h6C,
    A_PIXI = 'h70, A_SKIP = 'h74, A_TBASE = 'h78;
  localparam logic [ADDR_W-1:0] VID_LO = 'h80, VID_HI = 'hFC;
  localparam logic [31:0] M_SIZE = 32'h07FF07FF, M_TIM = 32'h0FF0FF3F, M_COL = 32'h00FFFFFF;

  typedef struct packed {
    logic [31:0] idle, ctrl, cfg, cap, bg0, bg1, key0, key1, line;
    logic [31:0] htim, vtim, pol, div, dsize, lsize;
    logic [31:0] base0, base1, pos, gsize, attr, thr, rowi, pixi, skip, tbase;
    logic [IRQ_W-1:0] stat, en;
  } regs_t;

  localparam regs_t RST = '{cap: 32'h161, rowi: 32'd1, pixi: 32'd1, default: '0};

  regs_t r;
  logic  wr, rd, hit;
  logic [31:0] mux;

  assign wr     = req_valid & req_write;
  assign rd     = req_valid & ~req_write;
  assign irq    = |(r.stat & r.en);
  assign lcd_en = r.ctrl[0];
  assign dig_en = r.ctrl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r <= RST;
    end else begin
      if (wr) begin
        if (req_addr == A_SCFG && req_wdata[1]) begin
          r      <= RST;
          r.idle <= req_wdata & 32'h301B;
        end else begin
          case (req_addr)
            A_SCFG:  r.idle  <= req_wdata & 32'h301B;
            A_ISTAT: r.stat  <= r.stat & ~req_wdata[IRQ_W-1:0];
            A_IEN:   r.en    <= req_wdata[IRQ_W-1:0];
            A_CTRL:  r.ctrl  <= req_wdata & 32'h07FF9FFF;
            A_CFG:   r.cfg   <= req_wdata & 32'h3FFF;
            A_CAP:   r.cap   <= req_wdata & 32'h3FF;
            A_BG0:   r.bg0   <= req_wdata & M_COL;
            A_BG1:   r.bg1   <= req_wdata & M_COL;
            A_KEY0:  r.key0  <= req_wdata & M_COL;
            A_KEY1:  r.key1  <= req_wdata & M_COL;
            A_LINE:  r.line  <= req_wdata & 32'h7FF;
            A_HTIM:  r.htim  <= req_wdata & M_TIM;
            A_VTIM:  r.vtim  <= req_wdata & M_TIM;
            A_POL:   r.pol   <= req_wdata & 32'h0003FFFF;
            A_DIV:   r.div   <= req_wdata & 32'h00FF00FF;
            A_DSIZE: r.dsize <= req_wdata & M_SIZE;
            A_LSIZE: r.lsize <= req_wdata & M_SIZE;
            A_BASE0: r.base0 <= req_wdata;
            A_BASE1: r.base1 <= req_wdata;
            A_POS:   r.pos   <= req_wdata & M_SIZE;
            A_GSIZE: r.gsize <= req_wdata & M_SIZE;
            A_ATTR:  r.attr  <= req_wdata & 32'h7FF;
            A_THR:   r.thr   <= req_wdata & 32'h01FF01FF;
            A_ROWI:  r.rowi  <= req_wdata;
            A_PIXI:  r.pixi  <= req_wdata;
            A_SKIP:  r.skip  <= req_wdata;
            A_TBASE: r.tbase <= req_wdata;
            default: ;
          endcase
        end
      end
      if (frame_done) r.stat[0] <= 1'b1;
    end
  end

  always_comb begin
    hit = 1'b1;
    mux = '0;
    case (req_addr)
      A_REV:   mux = 32'h20;
      A_SSTAT: mux = 32'h1;
      A_SCFG:  mux = r.idle;
      A_ISTAT: mux = 32'(r.stat);
      A_IEN:   mux = 32'(r.en);
      A_CTRL:  mux = r.ctrl;
      A_CFG:   mux = r.cfg;
      A_CAP:   mux = r.cap;
      A_BG0:   mux = r.bg0;
      A_BG1:   mux = r.bg1;
      A_KEY0:  mux = r.key0;
      A_KEY1:  mux = r.key1;
      A_LSTAT: mux = 32'h7FF;
      A_LINE:  mux = r.line;
      A_HTIM:  mux = r.htim;
      A_VTIM:  mux = r.vtim;
      A_POL:   mux = r.pol;
      A_DIV:   mux = r.div;
      A_DSIZE: mux = r.dsize;
      A_LSIZE: mux = r.lsize;
      A_BASE0: mux = r.base0;
      A_BASE1: mux = r.base1;
      A_POS:   mux = r.pos;
      A_GSIZE: mux = r.gsize;
      A_ATTR:  mux = r.attr;
      A_THR:   mux = r.thr;
      A_FSTAT: mux = 32'd256;
      A_ROWI:  mux = r.rowi;
      A_PIXI:  mux = r.pixi;
      A_SKIP:  mux = r.skip;
      A_TBASE: mux = r.tbase;
      default: hit = (req_addr[1:0] == 2'b00) && (req_addr >= VID_LO) && (req_addr <= VID_HI);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bad_addr <= 1'b0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? mux : '0;
      bad_addr <= rd & ~hit;
    end
  end
endmodule

// File: rtl/dispc_regs_chk.sv
module dispc_regs_chk #(
  parameter int ADDR_W = 10,
  parameter int IRQ_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              frame_done,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              bad_addr,
  input logic              irq,
  input logic              lcd_en,
  input logic              dig_en,
  input logic [IRQ_W-1:0]  stat,
  input logic [IRQ_W-1:0]  en
);
  localparam logic [ADDR_W-1:0] C_REV = 'h00, C_ISTAT = 'h0C, C_IEN = 'h10, C_CTRL = 'h14;

  a_r7_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> stat[0]);

  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == C_ISTAT && !frame_done) |=>
      ((stat & $past(req_wdata[IRQ_W-1:0])) == '0));

  a_r8_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == C_IEN && req_wdata[IRQ_W-1:0] == '0) |=> !irq);

  a_r4_panels: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == C_CTRL) |=>
      (lcd_en == $past(req_wdata[0]) && dig_en == $past(req_wdata[1])));

  a_r12_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r11_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> (rd_valid && rd_data == '0));

  a_r3_rev: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == C_REV) |=> (rd_data == 32'h20));
endmodule

bind dispc_regs dispc_regs_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .frame_done(frame_done),
  .rd_valid(rd_valid), .rd_data(rd_data), .bad_addr(bad_addr), .irq(irq),
  .lcd_en(lcd_en), .dig_en(dig_en), .stat(r.stat), .en(r.en));

// File: tb/dispc_regs_test.sv
module dispc_regs_test;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, frame_done = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, bad_addr, irq, lcd_en, dig_en;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  logic [31:0] m [0:31];

  always #5 clk = ~clk;

  dispc_regs #(.ADDR_W(AW), .IRQ_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .frame_done(frame_done),
    .rd_valid(rd_valid), .rd_data(rd_data), .bad_addr(bad_addr), .irq(irq),
    .lcd_en(lcd_en), .dig_en(dig_en));

  function automatic logic [31:0] wmask(int w);
    case (w)
      2: return 32'h301B;  3: return 32'hFFFF;  4: return 32'hFFFF;
      5: return 32'h07FF9FFF;  6: return 32'h3FFF;  7: return 32'h3FF;
      8, 9, 10, 11: return 32'hFFFFFF;  13: return 32'h7FF;
      14, 15: return 32'h0FF0FF3F;  16: return 32'h0003FFFF;  17: return 32'h00FF00FF;
      18, 19, 22, 23: return 32'h07FF07FF;  24: return 32'h7FF;  25: return 32'h01FF01FF;
      20, 21, 27, 28, 29, 30: return 32'hFFFFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m[i] = 0;
    m[0] = 32'h20; m[1] = 1; m[12] = 32'h7FF; m[26] = 256;
    m[7] = 32'h161; m[27] = 1; m[28] = 1;
  endtask

  function automatic logic [31:0] exp_read(logic [AW-1:0] a, output logic bad);
    bad = 0;
    if (a[1:0] == 0 && a <= 'h78) return m[a[AW-1:2]];
    if (a[1:0] == 0 && a >= 'h80 && a <= 'hFC) return 0;
    bad = 1;
    return 0;
  endfunction

  function automatic logic exp_irq();
    return |(m[3][15:0] & m[4][15:0]);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic v, logic w, logic [AW-1:0] a, logic [31:0] d, logic fd, string tag);
    logic [31:0] er;
    logic eb;
    int wd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; frame_done = fd;
    er = exp_read(a, eb);
    @(posedge clk);
    #1;
    if (v && w && a[1:0] == 0 && a <= 'h78) begin
      wd = int'(a[AW-1:2]);
      if (wd == 2 && d[1]) begin
        model_reset();
        m[2] = d & 32'h301B;
      end else if (wd == 3) m[3] = m[3] & ~(d & 32'hFFFF);
      else if (wmask(wd) != 0) m[wd] = d & wmask(wd);
    end
    if (fd) m[3][0] = 1'b1;
    if (v && !w) begin
      check({tag, " R12 rd_valid"}, 32'(rd_valid), 1);
      check({tag, " rd_data"}, rd_data, er);
      check({tag, " R11 bad_addr"}, 32'(bad_addr), 32'(eb));
    end else if (!v) check({tag, " R12 idle"}, 32'(rd_valid), 0);
    check({tag, " R8 irq"}, 32'(irq), 32'(exp_irq()));
    check({tag, " R4 panels"}, {30'd0, dig_en, lcd_en}, {30'd0, m[5][1:0]});
  endtask

  task automatic rd(logic [AW-1:0] a, string tag); cycle(1, 0, a, 0, 0, tag); endtask
  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag); cycle(1, 1, a, d, 0, tag); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    void'($urandom(32'h1D5C0));
    repeat (3) @(posedge clk);
    rst_n = 1;
    for (int i = 0; i < 32; i++) rd(AW'(i * 4), "R1 R3 reset read");
    for (int i = 0; i < 31; i++) wr(AW'(i * 4), 32'hFFFFFFFF, "R2 all-ones");
    for (int i = 0; i < 32; i++) rd(AW'(i * 4), "R2 R3 R5 masked read");
    wr('h48, 32'h0123_0456, "R5 dsize"); rd('h48, "R5 dsize");
    wr('h5C, 32'hF800_F800, "R5 gsize"); rd('h5C, "R5 gsize");
    wr('h14, 32'h1, "R4 lcd"); wr('h14, 32'h2, "R4 dig");
    wr('h10, 32'hFFFF_0001, "R6 enable"); rd('h10, "R6 enable");
    cycle(0, 0, 0, 0, 1, "R7 frame");
    cycle(1, 1, 'h0C, 32'h1, 1, "R7 clear collides");
    rd('h0C, "R7 set wins");
    wr('h0C, 32'h1, "R6 w1c"); rd('h0C, "R6 w1c");
    cycle(0, 0, 0, 0, 1, "R8 frame");
    wr('h10, 32'h0, "R8 mask off");
    cycle(1, 1, 'h08, 32'hFFFF_FFFF, 1, "R9 R7 soft reset collides");
    for (int i = 0; i < 32; i++) rd(AW'(i * 4), "R9 after soft reset");
    wr('h80, 32'hDEAD_BEEF, "R10 video"); rd('h80, "R10 video"); rd('hFC, "R10 video");
    rd('h7C, "R11 hole"); rd('h82, "R11 unaligned"); rd('h100, "R11 high");
    wr('h100, 32'h5, "R11 ignored"); rd('h18, "R11 ignored");
    for (int n = 0; n < 3000; n++) begin
      int unsigned p = $urandom_range(99);
      logic [AW-1:0] a;
      logic [31:0] d = $urandom();
      if (p < 70) a = AW'($urandom_range(31) * 4);
      else if (p < 80) a = AW'('h80 + $urandom_range(31) * 4);
      else a = AW'($urandom());
      if (a == 'h08 && $urandom_range(3) != 0) d[1] = 1'b0;
      cycle($urandom_range(5) != 0, $urandom_range(1) == 1, a, d,
            $urandom_range(7) == 0, "random R2 R6 R7 R8 R9");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule